// File: doc/BRIEF.md
# Coherent Home Node Read Controller

This block is the home for a range of cache lines in a small coherent system. It keeps a per-line directory with a presence bit for each requester and a flag that marks a sole owner. It serves shared-read requests from the requesters. When another requester owns the line alone, the home sends a snoop to that one cache and to no other. When no other requester owns the line alone, the home reads the line from a memory-side node.

Data reaches the requester in one of two ways. It can pass through the home, which holds it in a one-line buffer and resends it. It can also go straight from the source to the requester. Two static mode inputs choose direct delivery: one for memory reads and one for snoops. In every mode the home closes each transaction with a completion to the requester. The completion is sent only after the data has been delivered or the source has confirmed delivery. It then updates the directory.

The controller handles one transaction at a time. A new request is accepted only when the previous one has finished its completion handshake. A later request to the same line therefore sees a directory that is already up to date. Every channel is a valid/ready pair: a valid, once raised, stays high with its payload unchanged until ready is seen.

Top module: `home_node_ctrl`

## Requirements
- R1: After reset every directory entry is empty, `req_ready` is 1, and `snp_valid`, `mem_valid`, `dat_valid` and `cmp_valid` are 0.
- R2: A read to a line with no holders at all produces one memory request with `mem_tgt` = requester, `mem_line` = line and `mem_direct` = `cfg_mem_direct`. Its completion has `cmp_own` = 1, and the directory then records the requester as sole owner.
- R3: A read to a line whose sole owner is a different requester produces exactly one snoop, with `snp_tgt` = that owner and `snp_line` = line, and no memory request. The snoop is held stable until accepted.
- R4: With `cfg_peer_direct` = 0, the home waits for both the snoop acknowledge (`sack`) and the snoop data (`sdat`). It then sends that data on `dat_data` with `dat_tgt` = requester, followed by a completion with `cmp_own` = 0.
- R5: After a snoop-served read, both the former owner and the requester are recorded as holders and neither as sole owner. A later read by a third requester is therefore served from memory with `cmp_own` = 0. A line marked sole-owned always has exactly one holder.
- R6: With `cfg_mem_direct` = 1, a memory-served read raises no `dat_valid`, ignores `mdat_data`, and sends its completion after the `mdat` confirmation. With `cfg_mem_direct` = 0, the home forwards `mdat_data` on the data channel before the completion.
- R7: With `cfg_peer_direct` = 1, the snoop carries `snp_fwd` = 1 and `snp_fwd_tgt` = requester. The home holds `sdat_ready` at 0, raises no `dat_valid`, and sends the completion after the acknowledge alone.
- R8: A read to a line held only by sharers (none sole owner) goes to memory, not to a snoop, and completes with `cmp_own` = 0.
- R9: A re-read by the line's own sole owner goes to memory with no snoop, completes with `cmp_own` = 1, and leaves it sole owner.
- R10: From the cycle after a request is accepted until its completion handshake, `req_ready` is 0, so a second request waits and all of its channel traffic follows the first one's completion.
- R11: When data passes through the home, the data-channel handshake comes before `cmp_valid` rises. `cmp_valid` and its payload stay stable until `cmp_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mem_direct | input | 1 | Static: memory delivers data straight to requester |
| cfg_peer_direct | input | 1 | Static: snooped cache forwards data straight to requester |
| req_valid | input | 1 | Shared-read request valid |
| req_ready | output | 1 | Request accepted |
| req_src | input | IDW | Requester id |
| req_line | input | LW | Line index |
| snp_valid | output | 1 | Snoop valid |
| snp_ready | input | 1 | Snoop accepted |
| snp_tgt | output | IDW | Snooped owner |
| snp_line | output | LW | Snooped line |
| snp_fwd | output | 1 | Forward data directly to requester |
| snp_fwd_tgt | output | IDW | Requester to forward to |
| sack_valid | input | 1 | Snoop acknowledge from owner |
| sack_ready | output | 1 | Acknowledge accepted |
| sdat_valid | input | 1 | Snoop data valid |
| sdat_ready | output | 1 | Snoop data accepted |
| sdat_data | input | DATA_W | Snoop data |
| mem_valid | output | 1 | Memory read valid |
| mem_ready | input | 1 | Memory read accepted |
| mem_line | output | LW | Line to read |
| mem_direct | output | 1 | Memory sends data to requester directly |
| mem_tgt | output | IDW | Requester id |
| mdat_valid | input | 1 | Memory data or direct-delivery confirmation |
| mdat_ready | output | 1 | Memory data accepted |
| mdat_data | input | DATA_W | Memory data |
| dat_valid | output | 1 | Relayed data valid |
| dat_ready | input | 1 | Relayed data accepted |
| dat_tgt | output | IDW | Data destination |
| dat_data | output | DATA_W | Relayed data |
| cmp_valid | output | 1 | Completion valid |
| cmp_ready | input | 1 | Completion accepted |
| cmp_tgt | output | IDW | Completion destination |
| cmp_line | output | LW | Completed line |
| cmp_own | output | 1 | 1: granted as sole owner, 0: shared |

## Verification
The embedded assertions check several properties on every cycle. A snoop is aimed only at a recorded sole owner other than the requester. Snoop and completion payloads hold steady under backpressure. `req_ready` drops right after an accept and stays low while any outbound channel is busy. Snoop data is never taken in peer-direct mode. No relayed data follows a direct memory read. No directory entry is marked sole-owned with other than one holder. The bench scenarios cover what depends on history: the sharing state left by earlier reads and the exact order of snoop, memory, data and completion events in each mode. They also show the data values returned and that a stalled second request runs only after the first has completed.

// File: rtl/hn_pkg.sv
package hn_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_SNP,
        ST_SWAIT,
        ST_MEM,
        ST_MWAIT,
        ST_DOUT,
        ST_CMP
    } hn_state_e;

    typedef struct packed {
        logic mem_direct;
        logic peer_direct;
    } hn_mode_t;

    // lowest set bit position of a presence vector (zero when none)
    function automatic int unsigned lowest_set(input logic [31:0] v);
        int unsigned idx;
        idx = 0;
        for (int i = 31; i >= 0; i--) begin
            if (v[i]) idx = i;
        end
        return idx;
    endfunction

endpackage

// File: rtl/hn_dir.sv
module hn_dir #(
    parameter int N_REQ   = 4,
    parameter int N_LINES = 16,
    localparam int LW     = $clog2(N_LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LW-1:0]    rd_line,
    output logic [N_REQ-1:0] rd_pres,
    output logic             rd_own,
    input  logic             wr_en,
    input  logic [LW-1:0]    wr_line,
    input  logic [N_REQ-1:0] wr_pres,
    input  logic             wr_own
);
    logic [N_REQ-1:0] pres_q [N_LINES];
    logic             own_q  [N_LINES];

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                pres_q[i] <= '0;
                own_q[i]  <= 1'b0;
            end else if (wr_en && wr_line == LW'(i)) begin
                pres_q[i] <= wr_pres;
                own_q[i]  <= wr_own;
            end
        end

        // R5: a sole-owned line has exactly one holder
        p_own_single_r5: assert property (@(posedge clk) disable iff (rst)
            own_q[i] |-> $onehot(pres_q[i]));
    end

    assign rd_pres = pres_q[rd_line];
    assign rd_own  = own_q[rd_line];

endmodule

// File: rtl/hn_dbuf.sv
module hn_dbuf #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_peer,
    input  logic [DATA_W-1:0] peer_data,
    input  logic              ld_mem,
    input  logic [DATA_W-1:0] mem_data,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)          q <= '0;
        else if (ld_peer) q <= peer_data;
        else if (ld_mem)  q <= mem_data;
    end
endmodule

// File: rtl/hn_xact.sv
module hn_xact
    import hn_pkg::*;
#(
    parameter int N_REQ   = 4,
    parameter int N_LINES = 16,
    localparam int IDW    = $clog2(N_REQ),
    localparam int LW     = $clog2(N_LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_mem_direct,
    input  logic             cfg_peer_direct,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [IDW-1:0]   req_src,
    input  logic [LW-1:0]    req_line,
    output logic             snp_valid,
    input  logic             snp_ready,
    output logic [IDW-1:0]   snp_tgt,
    output logic [LW-1:0]    snp_line,
    output logic             snp_fwd,
    output logic [IDW-1:0]   snp_fwd_tgt,
    input  logic             sack_valid,
    output logic             sack_ready,
    input  logic             sdat_valid,
    output logic             sdat_ready,
    output logic             mem_valid,
    input  logic             mem_ready,
    output logic [LW-1:0]    mem_line,
    output logic             mem_direct,
    output logic [IDW-1:0]   mem_tgt,
    input  logic             mdat_valid,
    output logic             mdat_ready,
    output logic             dat_valid,
    input  logic             dat_ready,
    output logic [IDW-1:0]   dat_tgt,
    output logic             cmp_valid,
    input  logic             cmp_ready,
    output logic [IDW-1:0]   cmp_tgt,
    output logic [LW-1:0]    cmp_line,
    output logic             cmp_own,
    output logic [LW-1:0]    dir_rd_line,
    input  logic [N_REQ-1:0] dir_rd_pres,
    input  logic             dir_rd_own,
    output logic             dir_wr_en,
    output logic [N_REQ-1:0] dir_wr_pres,
    output logic             dir_wr_own,
    output logic             ld_peer,
    output logic             ld_mem
);
    hn_state_e        st_q;
    hn_mode_t         mode_q;
    logic [IDW-1:0]   src_q;
    logic [IDW-1:0]   holder_q;
    logic [LW-1:0]    line_q;
    logic             others_q;
    logic             got_ack_q;
    logic             got_dat_q;

    logic [N_REQ-1:0] src_bit;
    logic [N_REQ-1:0] others;
    logic [31:0]      others_ext;
    logic             sack_hs;
    logic             sdat_hs;
    logic             snoop_done;

    assign src_bit = {{(N_REQ-1){1'b0}}, 1'b1} << src_q;
    assign others  = dir_rd_pres & ~src_bit;

    always_comb begin
        others_ext = '0;
        others_ext[N_REQ-1:0] = others;
    end

    assign req_ready   = (st_q == ST_IDLE);
    assign snp_valid   = (st_q == ST_SNP);
    assign mem_valid   = (st_q == ST_MEM);
    assign dat_valid   = (st_q == ST_DOUT);
    assign cmp_valid   = (st_q == ST_CMP);
    assign sack_ready  = (st_q == ST_SWAIT) && !got_ack_q;
    assign sdat_ready  = (st_q == ST_SWAIT) && !got_dat_q;
    assign mdat_ready  = (st_q == ST_MWAIT);

    assign snp_tgt     = holder_q;
    assign snp_line    = line_q;
    assign snp_fwd     = mode_q.peer_direct;
    assign snp_fwd_tgt = src_q;
    assign mem_line    = line_q;
    assign mem_direct  = mode_q.mem_direct;
    assign mem_tgt     = src_q;
    assign dat_tgt     = src_q;
    assign cmp_tgt     = src_q;
    assign cmp_line    = line_q;
    assign cmp_own     = !others_q;

    assign sack_hs    = sack_valid && sack_ready;
    assign sdat_hs    = sdat_valid && sdat_ready;
    assign snoop_done = (got_ack_q || sack_hs) && (got_dat_q || sdat_hs);

    assign dir_rd_line = line_q;
    assign dir_wr_en   = cmp_valid && cmp_ready;
    assign dir_wr_pres = dir_rd_pres | src_bit;
    assign dir_wr_own  = !others_q;

    assign ld_peer = (st_q == ST_SWAIT) && sdat_hs;
    assign ld_mem  = (st_q == ST_MWAIT) && mdat_valid && !mode_q.mem_direct;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            mode_q    <= '0;
            src_q     <= '0;
            holder_q  <= '0;
            line_q    <= '0;
            others_q  <= 1'b0;
            got_ack_q <= 1'b0;
            got_dat_q <= 1'b0;
        end else begin
            unique case (st_q)
                ST_IDLE: if (req_valid) begin
                    src_q  <= req_src;
                    line_q <= req_line;
                    mode_q <= '{mem_direct: cfg_mem_direct, peer_direct: cfg_peer_direct};
                    st_q   <= ST_LOOK;
                end
                ST_LOOK: begin
                    others_q <= |others;
                    if (dir_rd_own && |others) begin
                        holder_q <= IDW'(lowest_set(others_ext));
                        st_q     <= ST_SNP;
                    end else begin
                        st_q <= ST_MEM;
                    end
                end
                ST_SNP: if (snp_ready) begin
                    got_ack_q <= 1'b0;
                    got_dat_q <= mode_q.peer_direct;
                    st_q      <= ST_SWAIT;
                end
                ST_SWAIT: begin
                    if (sack_hs) got_ack_q <= 1'b1;
                    if (sdat_hs) got_dat_q <= 1'b1;
                    if (snoop_done) st_q <= mode_q.peer_direct ? ST_CMP : ST_DOUT;
                end
                ST_MEM: if (mem_ready) st_q <= ST_MWAIT;
                ST_MWAIT: if (mdat_valid) st_q <= mode_q.mem_direct ? ST_CMP : ST_DOUT;
                ST_DOUT: if (dat_ready) st_q <= ST_CMP;
                ST_CMP: if (cmp_ready) st_q <= ST_IDLE;
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R10: accepting a request closes the request channel next cycle
    p_req_stall_r10: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> !req_ready);

    // R10: no outbound traffic while idle
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !(snp_valid || mem_valid || dat_valid || cmp_valid));

    // R3: snoop held stable under backpressure
    p_snp_hold_r3: assert property (@(posedge clk) disable iff (rst)
        snp_valid && !snp_ready |=> snp_valid && $stable(snp_tgt) && $stable(snp_line));

    // R11: completion held stable under backpressure
    p_cmp_hold_r11: assert property (@(posedge clk) disable iff (rst)
        cmp_valid && !cmp_ready |=> cmp_valid && $stable(cmp_tgt) && $stable(cmp_own));

    // R6: a direct memory read is never followed by relayed data
    p_dmt_nodata_r6: assert property (@(posedge clk) disable iff (rst)
        mem_valid && mem_direct |=> !dat_valid);

    // R7: snoop data is never taken in peer-direct mode
    p_dct_nosdat_r7: assert property (@(posedge clk) disable iff (rst)
        cfg_peer_direct && mode_q.peer_direct |-> !sdat_ready);

endmodule

// File: rtl/home_node_ctrl.sv
module home_node_ctrl #(
    parameter int N_REQ   = 4,
    parameter int N_LINES = 16,
    parameter int DATA_W  = 16,
    localparam int IDW    = $clog2(N_REQ),
    localparam int LW     = $clog2(N_LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_mem_direct,
    input  logic              cfg_peer_direct,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [IDW-1:0]    req_src,
    input  logic [LW-1:0]     req_line,
    output logic              snp_valid,
    input  logic              snp_ready,
    output logic [IDW-1:0]    snp_tgt,
    output logic [LW-1:0]     snp_line,
    output logic              snp_fwd,
    output logic [IDW-1:0]    snp_fwd_tgt,
    input  logic              sack_valid,
    output logic              sack_ready,
    input  logic              sdat_valid,
    output logic              sdat_ready,
    input  logic [DATA_W-1:0] sdat_data,
    output logic              mem_valid,
    input  logic              mem_ready,
    output logic [LW-1:0]     mem_line,
    output logic              mem_direct,
    output logic [IDW-1:0]    mem_tgt,
    input  logic              mdat_valid,
    output logic              mdat_ready,
    input  logic [DATA_W-1:0] mdat_data,
    output logic              dat_valid,
    input  logic              dat_ready,
    output logic [IDW-1:0]    dat_tgt,
    output logic [DATA_W-1:0] dat_data,
    output logic              cmp_valid,
    input  logic              cmp_ready,
    output logic [IDW-1:0]    cmp_tgt,
    output logic [LW-1:0]     cmp_line,
    output logic              cmp_own
);
    logic [LW-1:0]    dir_rd_line;
    logic [N_REQ-1:0] dir_rd_pres;
    logic             dir_rd_own;
    logic             dir_wr_en;
    logic [N_REQ-1:0] dir_wr_pres;
    logic             dir_wr_own;
    logic             ld_peer;
    logic             ld_mem;

    hn_dir #(.N_REQ(N_REQ), .N_LINES(N_LINES)) u_dir (
        .clk     (clk),
        .rst     (rst),
        .rd_line (dir_rd_line),
        .rd_pres (dir_rd_pres),
        .rd_own  (dir_rd_own),
        .wr_en   (dir_wr_en),
        .wr_line (cmp_line),
        .wr_pres (dir_wr_pres),
        .wr_own  (dir_wr_own)
    );

    hn_dbuf #(.DATA_W(DATA_W)) u_dbuf (
        .clk       (clk),
        .rst       (rst),
        .ld_peer   (ld_peer),
        .peer_data (sdat_data),
        .ld_mem    (ld_mem),
        .mem_data  (mdat_data),
        .q         (dat_data)
    );

    hn_xact #(.N_REQ(N_REQ), .N_LINES(N_LINES)) u_xact (
        .clk             (clk),
        .rst             (rst),
        .cfg_mem_direct  (cfg_mem_direct),
        .cfg_peer_direct (cfg_peer_direct),
        .req_valid       (req_valid),
        .req_ready       (req_ready),
        .req_src         (req_src),
        .req_line        (req_line),
        .snp_valid       (snp_valid),
        .snp_ready       (snp_ready),
        .snp_tgt         (snp_tgt),
        .snp_line        (snp_line),
        .snp_fwd         (snp_fwd),
        .snp_fwd_tgt     (snp_fwd_tgt),
        .sack_valid      (sack_valid),
        .sack_ready      (sack_ready),
        .sdat_valid      (sdat_valid),
        .sdat_ready      (sdat_ready),
        .mem_valid       (mem_valid),
        .mem_ready       (mem_ready),
        .mem_line        (mem_line),
        .mem_direct      (mem_direct),
        .mem_tgt         (mem_tgt),
        .mdat_valid      (mdat_valid),
        .mdat_ready      (mdat_ready),
        .dat_valid       (dat_valid),
        .dat_ready       (dat_ready),
        .dat_tgt         (dat_tgt),
        .cmp_valid       (cmp_valid),
        .cmp_ready       (cmp_ready),
        .cmp_tgt         (cmp_tgt),
        .cmp_line        (cmp_line),
        .cmp_own         (cmp_own),
        .dir_rd_line     (dir_rd_line),
        .dir_rd_pres     (dir_rd_pres),
        .dir_rd_own      (dir_rd_own),
        .dir_wr_en       (dir_wr_en),
        .dir_wr_pres     (dir_wr_pres),
        .dir_wr_own      (dir_wr_own),
        .ld_peer         (ld_peer),
        .ld_mem          (ld_mem)
    );

    // R3: a snoop goes only to the recorded sole owner, never to the requester
    p_snoop_owner_r3: assert property (@(posedge clk) disable iff (rst)
        snp_valid |-> dir_rd_own && dir_rd_pres[snp_tgt] && (snp_tgt != snp_fwd_tgt));

endmodule

// File: tb/test_home_node_ctrl.sv
module test_home_node_ctrl;

    typedef struct packed {
        logic [1:0]  kind;   // 0 snoop, 1 memory, 2 data, 3 completion
        logic [1:0]  tgt;
        logic [3:0]  line;
        logic [15:0] val;
    } ev_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_mem_direct = 1'b0, cfg_peer_direct = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [1:0] req_src = '0;
    logic [3:0] req_line = '0;
    logic snp_valid, snp_ready = 1'b0, snp_fwd;
    logic [1:0] snp_tgt, snp_fwd_tgt;
    logic [3:0] snp_line;
    logic sack_valid = 1'b0, sack_ready;
    logic sdat_valid = 1'b0, sdat_ready;
    logic [15:0] sdat_data = '0;
    logic mem_valid, mem_ready = 1'b0, mem_direct;
    logic [3:0] mem_line;
    logic [1:0] mem_tgt;
    logic mdat_valid = 1'b0, mdat_ready;
    logic [15:0] mdat_data = '0;
    logic dat_valid, dat_ready = 1'b0;
    logic [1:0] dat_tgt;
    logic [15:0] dat_data;
    logic cmp_valid, cmp_ready = 1'b0, cmp_own;
    logic [1:0] cmp_tgt;
    logic [3:0] cmp_line;

    always #10 clk = ~clk;

    home_node_ctrl i_home_node_ctrl (
        .clk(clk), .rst(rst),
        .cfg_mem_direct(cfg_mem_direct), .cfg_peer_direct(cfg_peer_direct),
        .req_valid(req_valid), .req_ready(req_ready), .req_src(req_src), .req_line(req_line),
        .snp_valid(snp_valid), .snp_ready(snp_ready), .snp_tgt(snp_tgt), .snp_line(snp_line),
        .snp_fwd(snp_fwd), .snp_fwd_tgt(snp_fwd_tgt),
        .sack_valid(sack_valid), .sack_ready(sack_ready),
        .sdat_valid(sdat_valid), .sdat_ready(sdat_ready), .sdat_data(sdat_data),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_line(mem_line),
        .mem_direct(mem_direct), .mem_tgt(mem_tgt),
        .mdat_valid(mdat_valid), .mdat_ready(mdat_ready), .mdat_data(mdat_data),
        .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_tgt(dat_tgt), .dat_data(dat_data),
        .cmp_valid(cmp_valid), .cmp_ready(cmp_ready), .cmp_tgt(cmp_tgt),
        .cmp_line(cmp_line), .cmp_own(cmp_own)
    );

    int checks = 0;
    int failures = 0;
    ev_t   exp_q[$];
    string tag_q[$];
    logic [3:0] m_pres [16];
    logic       m_own  [16];

    function automatic logic [15:0] peer_word(input logic [1:0] h, input logic [3:0] l);
        return {4'hC, 2'b00, h, 4'h0, l};
    endfunction
    function automatic logic [15:0] mem_word(input logic [3:0] l);
        return {8'h5A, 4'h3, l};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic push(input ev_t e, input string req);
        exp_q.push_back(e);
        tag_q.push_back(req);
    endtask

    // handshake capture at the clock edge
    logic hs_snp = 0, hs_mem = 0, hs_dat = 0, hs_cmp = 0, hs_sack = 0, hs_sdat = 0, hs_mdat = 0;
    ev_t  c_snp, c_mem, c_dat, c_cmp;
    always @(posedge clk) begin
        hs_snp  <= snp_valid && snp_ready;
        hs_mem  <= mem_valid && mem_ready;
        hs_dat  <= dat_valid && dat_ready;
        hs_cmp  <= cmp_valid && cmp_ready;
        hs_sack <= sack_valid && sack_ready;
        hs_sdat <= sdat_valid && sdat_ready;
        hs_mdat <= mdat_valid && mdat_ready;
        c_snp   <= '{kind: 2'd0, tgt: snp_tgt, line: snp_line, val: {13'd0, snp_fwd, snp_fwd_tgt}};
        c_mem   <= '{kind: 2'd1, tgt: mem_tgt, line: mem_line, val: {15'd0, mem_direct}};
        c_dat   <= '{kind: 2'd2, tgt: dat_tgt, line: 4'd0, val: dat_data};
        c_cmp   <= '{kind: 2'd3, tgt: cmp_tgt, line: cmp_line, val: {15'd0, cmp_own}};
    end

    task automatic score(input ev_t got);
        ev_t   e;
        string t;
        if (exp_q.size() == 0) begin
            check(1'b0, "R10", "unexpected event", 32'(got), 32'hFFFF_FFFF);
        end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(got == e, t, "event", 32'(got), 32'(e));
        end
    endtask

    // monitor, responders and ready patterns, all at the falling edge
    int cyc = 0;
    int ack_cd = 0, sd_cd = 0, md_cd = 0;
    logic [1:0] p_h = '0;
    logic [3:0] p_l = '0, m_l = '0;
    int sdat_leak = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (hs_snp) begin score(c_snp); p_h = c_snp.tgt; p_l = c_snp.line; ack_cd = 2; sd_cd = 3; end
            if (hs_mem) begin score(c_mem); m_l = c_mem.line; md_cd = 3; end
            if (hs_dat) score(c_dat);
            if (hs_cmp) begin score(c_cmp); sdat_valid = 1'b0; end
            if (hs_sack) sack_valid = 1'b0;
            if (hs_sdat) begin
                sdat_valid = 1'b0;
                if (cfg_peer_direct) sdat_leak++;
            end
            if (hs_mdat) mdat_valid = 1'b0;
            if (ack_cd > 0) begin ack_cd--; if (ack_cd == 0) sack_valid = 1'b1; end
            if (sd_cd > 0) begin
                sd_cd--;
                if (sd_cd == 0) begin sdat_valid = 1'b1; sdat_data = peer_word(p_h, p_l); end
            end
            if (md_cd > 0) begin
                md_cd--;
                if (md_cd == 0) begin mdat_valid = 1'b1; mdat_data = mem_word(m_l); end
            end
        end
        cyc++;
        snp_ready = (cyc % 3) != 0;
        mem_ready = (cyc % 2) == 0;
        dat_ready = (cyc % 4) != 1;
        cmp_ready = (cyc % 5) != 2;
    end

    // independent expectation model built from the requirements
    task automatic do_read(input logic [1:0] src, input logic [3:0] line, input string req);
        logic [3:0] sb, oth;
        logic [1:0] h;
        sb  = 4'b0001 << src;
        oth = m_pres[line] & ~sb;
        if (m_own[line] && oth != 0) begin
            h = 2'd0;
            for (int i = 3; i >= 0; i--) if (oth[i]) h = 2'(i);
            push('{kind: 2'd0, tgt: h, line: line, val: {13'd0, cfg_peer_direct, src}}, req);
            if (!cfg_peer_direct)
                push('{kind: 2'd2, tgt: src, line: 4'd0, val: peer_word(h, line)}, req);
            push('{kind: 2'd3, tgt: src, line: line, val: 16'd0}, req);
            m_own[line] = 1'b0;
        end else begin
            push('{kind: 2'd1, tgt: src, line: line, val: {15'd0, cfg_mem_direct}}, req);
            if (!cfg_mem_direct)
                push('{kind: 2'd2, tgt: src, line: 4'd0, val: mem_word(line)}, req);
            push('{kind: 2'd3, tgt: src, line: line, val: {15'd0, (oth == 0)}}, req);
            m_own[line] = (oth == 0);
        end
        m_pres[line] = m_pres[line] | sb;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_src = src; req_line = line;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain(input string req);
        int n = 0;
        while ((exp_q.size() != 0 || !req_ready) && n < 400) begin
            @(negedge clk);
            n++;
        end
        check(exp_q.size() == 0, req, "all expected events seen", 32'(exp_q.size()), 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin m_pres[i] = '0; m_own[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        check(req_ready === 1'b1, "R1", "req_ready after reset", 32'(req_ready), 32'd1);
        check({snp_valid, mem_valid, dat_valid, cmp_valid} === 4'b0, "R1", "valids after reset",
              32'({snp_valid, mem_valid, dat_valid, cmp_valid}), 32'd0);

        // relay modes
        do_read(2'd0, 4'd3, "R2");  drain("R2");     // empty line -> memory, sole owner
        do_read(2'd1, 4'd3, "R4");  drain("R3");     // owner 0 snooped, data relayed
        do_read(2'd2, 4'd3, "R5");  drain("R5");     // sharers only -> memory, shared
        do_read(2'd2, 4'd3, "R8");  drain("R8");     // re-read while shared
        do_read(2'd1, 4'd7, "R2");  drain("R2");
        do_read(2'd1, 4'd7, "R9");  drain("R9");     // owner re-reads itself
        do_read(2'd3, 4'd0, "R11"); drain("R11");    // line 0 boundary

        // direct memory delivery
        cfg_mem_direct = 1'b1;
        do_read(2'd3, 4'd9, "R6");  drain("R6");
        do_read(2'd2, 4'd15, "R6"); drain("R6");     // top line boundary
        // direct peer delivery
        cfg_peer_direct = 1'b1;
        do_read(2'd0, 4'd9, "R7");  drain("R7");
        check(sdat_leak == 0, "R7", "snoop data accepted in direct mode", 32'(sdat_leak), 32'd0);
        do_read(2'd1, 4'd9, "R5");  drain("R5");     // two sharers, memory, shared

        // stall of a second request behind a snoop-served one
        cfg_mem_direct = 1'b0;
        cfg_peer_direct = 1'b0;
        do_read(2'd0, 4'd11, "R2"); drain("R2");
        do_read(2'd1, 4'd11, "R10");
        check(req_ready === 1'b0, "R10", "req_ready during transaction", 32'(req_ready), 32'd0);
        do_read(2'd3, 4'd11, "R10");
        drain("R10");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired expected=finished actual=hung");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule